// File: doc/BRIEF.md
# Auto-Reload 8-bit Timer/Counter

This block is an 8-bit up-counter that counts pulses from a selectable source through a power-of-two prescaler. The source is either the core clock divided by four or one edge polarity of an external count pin, which is first synchronized to the core clock. When the counter passes FF it rolls back to a programmed reload value and raises a sticky interrupt request.

Software reaches the block through a narrow register port that carries 4-bit nibbles. To program the byte, software writes the low half into a staging nibble and then writes the high half, which updates the reload value and the live counter in one step. To read the live byte coherently, software reads the high half first. That read captures the low half, and a later low read returns the captured value.

Top module: `reload_timer8`

## Requirements
- R1: After reset the counter, reload value, mode field, control bits and interrupt request are all zero. Reads then return 0 at address 1 (counter high), address 2 (mode) and address 3 (control), and `irq_req` is 0.
- R2: A write to address 0 only stages the low nibble and leaves the counter unchanged. A write to address 1 loads {written nibble, staged nibble} into both the reload value and the counter at that clock edge. Both the divide-by-four phase and the prescaler restart at that edge.
- R3: With control bit 1 at 0, the count source is one pulse every 4 clocks. The counter gains one per 4·N clocks after a load, where N is the prescaler ratio.
- R4: The 3-bit mode field at address 2, bits 2:0, sets N as follows: 0→2048, 1→512, 2→128, 3→32, 4→8, 5→4, 6→2, 7→1. The counter advances once per N source pulses.
- R5: A count step taken while the counter holds FF loads the reload value instead of 00.
- R6: That rollover step sets `irq_req`. `irq_req` stays set until software writes a 0 in bit 0 at address 4. Writing a 1 there has no effect, and a rollover in the same cycle as a clear keeps the request set.
- R7: With control bit 1 (address 3) at 1, the count source is the external pin after a two-stage synchronizer. Control bit 0 at 0 counts rising edges only; at 1 it counts falling edges only. Each counted edge is one source pulse.
- R8: A read strobe at address 1 returns the counter's high nibble and captures its low nibble. A read at address 0 returns that captured nibble, not the live low nibble.
- R9: The mode field reads back at address 2 bits 2:0. The control bits read back at address 3 as bit 0 edge select and bit 1 source select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wdata | input | NIB_W (4) | Write nibble |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | NIB_W (4) | Read nibble for the current address |
| ext_cnt_pin | input | 1 | Asynchronous external count input |
| irq_req | output | 1 | Sticky rollover interrupt request |

## Verification
The bench builds the block with its default parameters: 4-bit nibbles, an 11-bit prescaler, a divide-by-four internal source and two synchronizer stages. Because the ratios span 1 to 2048, the short ratios can wrap the counter many times within a few thousand cycles. The longest ratio is also reached, and its first step is checked one clock before and at the exact cycle it occurs. Random loads and waits under ratios 1 to 32 cover rollover into arbitrary reload values. Directed sequences on the external pin show that each polarity is counted alone and that the prescaler applies to pin edges as well.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [2:0] {
    A_LOAD_LO = 3'd0,
    A_CNT_HI  = 3'd1,
    A_MODE    = 3'd2,
    A_CTRL    = 3'd3,
    A_IRQ     = 3'd4
  } tmr_addr_e;

  // log2 of the prescaler ratio for each mode code
  function automatic logic [4:0] pre_exp(input logic [MODE_W-1:0] m);
    logic [4:0] e;
    case (m)
      3'd0:    e = 5'd11;
      3'd1:    e = 5'd9;
      3'd2:    e = 5'd7;
      3'd3:    e = 5'd5;
      3'd4:    e = 5'd3;
      3'd5:    e = 5'd2;
      3'd6:    e = 5'd1;
      default: e = 5'd0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ext_pin,
  input  logic use_ext,
  input  logic fall_edge,
  output logic ext_edge,
  output logic src_tick
);
  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [DIV_W-1:0]     div_q;
  logic                 div_tick;
  logic [SYNC_STAGES:0] sync_q;
  logic                 s_new, s_old;

  assign div_tick = (div_q == DIV_W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (clr)      div_q <= '0;
    else if (div_tick) div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_pin};
  end

  assign s_new    = sync_q[SYNC_STAGES-1];
  assign s_old    = sync_q[SYNC_STAGES];
  assign ext_edge = fall_edge ? (s_old & ~s_new) : (s_new & ~s_old);
  assign src_tick = use_ext ? ext_edge : div_tick;

  // R7: a counted pin edge lasts one cycle
  a_r7_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge);

  // R3: the internal source pulses are spaced DIV cycles apart
  a_r3_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (div_tick && !clr) |=> !div_tick);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PRE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [MODE_W-1:0] mode,
  input  logic              src_tick,
  output logic              pre_tick
);
  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] mask;

  assign mask     = PRE_W'((32'd1 << pre_exp(mode)) - 32'd1);
  assign pre_tick = src_tick && ((pcnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt_q <= '0;
    else if (clr)      pcnt_q <= '0;
    else if (src_tick) pcnt_q <= pcnt_q + 1'b1;
  end

  // R4: a prescaled step needs a source pulse
  a_r4_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |-> src_tick);

  // R4: ratio 1 passes every source pulse
  a_r4_ratio_one: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd7 && src_tick) |-> pre_tick);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [2*NIB_W-1:0] commit_val,
  input  logic               cnt_tick,
  input  logic               rd_hi,
  output logic [2*NIB_W-1:0] cnt,
  output logic [NIB_W-1:0]   rd_lat,
  output logic               ovf
);
  localparam int CNT_W = 2 * NIB_W;

  logic [CNT_W-1:0] cnt_q, reload_q;
  logic [NIB_W-1:0] lat_q;
  logic             step;

  assign step = cnt_tick && !commit;
  assign ovf  = step && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (commit) begin
      cnt_q    <= commit_val;
      reload_q <= commit_val;
    end else if (ovf) begin
      cnt_q    <= reload_q;
    end else if (step) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lat_q <= '0;
    else if (rd_hi) lat_q <= cnt_q[NIB_W-1:0];
  end

  assign cnt    = cnt_q;
  assign rd_lat = lat_q;

  // R2: a load places the committed byte in the counter
  a_r2_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> cnt_q == $past(commit_val));

  // R5: a rollover step restores the reload value
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt_q == $past(reload_q));

  // R3: no step and no load leaves the count unchanged
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !commit) |=> $stable(cnt_q));

  // R8: a high read captures the low nibble seen in that cycle
  a_r8_latch: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> lat_q == $past(cnt_q[NIB_W-1:0]));

endmodule

// File: rtl/reload_timer8.sv
module reload_timer8
  import tmr_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int NIB_W       = 4,
  parameter int PRE_W       = 11,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NIB_W-1:0]  reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [NIB_W-1:0]  reg_rdata,
  input  logic              ext_cnt_pin,
  output logic              irq_req
);
  localparam int CNT_W = 2 * NIB_W;

  logic [NIB_W-1:0]  lo_stage_q;
  logic [MODE_W-1:0] mode_q;
  logic              fall_q, ext_q, irq_q;

  logic              wr_lo, commit, wr_mode, wr_ctrl, irq_clr, rd_hi;
  logic              ext_edge, src_tick, pre_tick, cnt_ovf;
  logic [CNT_W-1:0]  cnt;
  logic [NIB_W-1:0]  rd_lat;

  assign wr_lo   = reg_wr && (reg_addr == ADDR_W'(A_LOAD_LO));
  assign commit  = reg_wr && (reg_addr == ADDR_W'(A_CNT_HI));
  assign wr_mode = reg_wr && (reg_addr == ADDR_W'(A_MODE));
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
  assign irq_clr = reg_wr && (reg_addr == ADDR_W'(A_IRQ)) && !reg_wdata[0];
  assign rd_hi   = reg_rd && (reg_addr == ADDR_W'(A_CNT_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_stage_q <= '0;
      mode_q     <= '0;
      fall_q     <= 1'b0;
      ext_q      <= 1'b0;
    end else begin
      if (wr_lo)   lo_stage_q <= reg_wdata;
      if (wr_mode) mode_q     <= reg_wdata[MODE_W-1:0];
      if (wr_ctrl) begin
        fall_q <= reg_wdata[0];
        ext_q  <= reg_wdata[1];
      end
    end
  end

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (cnt_ovf) irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  assign irq_req = irq_q;

  tmr_src_sel #(.DIV(CLK_DIV), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .clr(commit), .ext_pin(ext_cnt_pin),
    .use_ext(ext_q), .fall_edge(fall_q), .ext_edge(ext_edge), .src_tick(src_tick)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(commit), .mode(mode_q),
    .src_tick(src_tick), .pre_tick(pre_tick)
  );

  tmr_counter #(.NIB_W(NIB_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .commit_val({reg_wdata, lo_stage_q}), .cnt_tick(pre_tick),
    .rd_hi(rd_hi), .cnt(cnt), .rd_lat(rd_lat), .ovf(cnt_ovf)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(A_LOAD_LO): reg_rdata = rd_lat;
      ADDR_W'(A_CNT_HI):  reg_rdata = cnt[CNT_W-1:NIB_W];
      ADDR_W'(A_MODE):    reg_rdata = NIB_W'(mode_q);
      ADDR_W'(A_CTRL):    reg_rdata = NIB_W'({ext_q, fall_q});
      ADDR_W'(A_IRQ):     reg_rdata = NIB_W'(irq_q);
      default:            reg_rdata = '0;
    endcase
  end

  // R6: a rollover raises the request
  a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ovf |=> irq_req);

  // R6: the request persists until a clear write
  a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_clr) |=> irq_req);

  // R6: the request rises only from a rollover
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !cnt_ovf) |=> !irq_req);

  // R9: the mode field keeps its value between mode writes
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode_q));

endmodule

// File: tb/tb_reload_timer8.sv
module tb_reload_timer8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [3:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [3:0] reg_rdata;
  logic       ext_cnt_pin = 1'b0;
  logic       irq_req;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  reload_timer8 dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .ext_cnt_pin(ext_cnt_pin), .irq_req(irq_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Ratio from the mode code, as stated in R4.
  function automatic int ratio_of(input int m);
    return (m < 4) ? (1 << (11 - 2 * m)) : (1 << (7 - m));
  endfunction

  // Counter value after a number of steps from a load, with the rollover flag.
  function automatic int model_cnt(input int ld, input int steps, output bit rolled);
    int v = ld;
    rolled = 0;
    for (int i = 0; i < steps; i++) begin
      if (v == 255) begin v = ld; rolled = 1; end
      else v = v + 1;
    end
    return v;
  endfunction

  // All tasks start and end just after a falling edge.
  task automatic wr(input int a, input int d);
    reg_addr = a[2:0]; reg_wdata = d[3:0]; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output int v);
    reg_addr = a[2:0]; reg_rd = 1'b1;
    #1 v = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_cnt(output int v);
    int hi, lo;
    rd_reg(1, hi);
    rd_reg(0, lo);
    v = hi * 16 + lo;
  endtask

  task automatic load(input int v);
    wr(0, v % 16);
    wr(1, v / 16);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_pulse();
    ext_cnt_pin = 1'b1; wait_n(4);
    ext_cnt_pin = 1'b0; wait_n(4);
  endtask

  initial begin
    #(1_900_000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, m, ld, n, el, st, expv;
    bit rolled;
    void'($urandom(32'd2718));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    check("R1 irq", int'(irq_req), 0);
    rd_reg(2, v); check("R1 mode", v, 0);
    rd_reg(3, v); check("R1 ctrl", v, 0);
    rd_cnt(v);    check("R1 count", v, 0);

    // R2 low write stages only, high write loads
    wr(0, 7);
    rd_cnt(v); check("R2 low write alone", v, 0);
    wr(1, 3);
    rd_cnt(v); check("R2 high write loads", v, 8'h37);

    // R9 readback
    for (int i = 0; i < 4; i++) begin
      m = $urandom_range(0, 7);
      wr(2, m); rd_reg(2, v); check("R9 mode readback", v, m);
    end
    wr(3, 2); rd_reg(3, v); check("R9 ctrl readback", v, 2);
    wr(3, 1); rd_reg(3, v); check("R9 ctrl readback", v, 1);
    wr(3, 0);

    // R3 internal source, ratio 1
    wr(2, 7);
    load(8'hA5);
    wait_n(40);
    rd_cnt(v); check("R3 div4 ratio1", v, 8'hAF);

    // R5/R6 rollover into reload and sticky request
    wr(4, 0);
    load(8'hFD);
    wr(4, 0);
    wait_n(11);
    check("R6 irq set on rollover", int'(irq_req), 1);
    rd_cnt(v); check("R5 reload after FF", v, 8'hFD);
    wr(2, 0);
    wait_n(20);
    check("R6 irq held", int'(irq_req), 1);
    wr(4, 1);
    check("R6 write one ignored", int'(irq_req), 1);
    wr(4, 0);
    check("R6 write zero clears", int'(irq_req), 0);

    // R8 latched low nibble
    wr(2, 7);
    load(8'h0C);
    wait_n(8);
    rd_reg(1, v); check("R8 high nibble", v, 0);
    wait_n(12);
    rd_reg(0, v); check("R8 latched low", v, 4'hE);
    rd_reg(1, v); check("R8 live high moved", v, 1);

    // R4 longest ratio: one step exactly at 4*2048 clocks
    wr(2, 0);
    load(8'h40);
    wait_n(8191);
    rd_cnt(v); check("R4 ratio 2048 before", v, 8'h40);
    load(8'h40);
    wait_n(8192);
    rd_cnt(v); check("R4 ratio 2048 at step", v, 8'h41);

    // R3/R4/R5/R6 random loads, ratios and waits
    for (int i = 0; i < 24; i++) begin
      m  = $urandom_range(3, 7);
      n  = ratio_of(m);
      ld = $urandom_range(0, 255);
      if (i % 4 == 0) ld = $urandom_range(240, 255);
      wr(2, m);
      load(ld);
      wr(4, 0);
      st = $urandom_range(0, 4 * n * 40);
      wait_n(st);
      el = st + 1;
      expv = model_cnt(ld, el / (4 * n), rolled);
      check("R6 random irq", int'(irq_req), int'(rolled));
      rd_cnt(v); check("R3 R4 R5 random count", v, expv);
    end

    // R7 external pin, rising edges
    wr(2, 7);
    wr(3, 2);
    load(8'h10);
    repeat (3) pin_pulse();
    rd_cnt(v); check("R7 rising edges", v, 8'h13);

    // R7 falling only: a rising edge alone does not count
    wr(3, 3);
    load(8'h20);
    ext_cnt_pin = 1'b1; wait_n(6);
    rd_cnt(v); check("R7 rising ignored when falling", v, 8'h20);
    ext_cnt_pin = 1'b0; wait_n(6);
    rd_cnt(v); check("R7 falling counted", v, 8'h21);

    // R4 prescaler applies to pin edges (ratio 2)
    wr(3, 2);
    wr(2, 6);
    load(8'h50);
    repeat (5) pin_pulse();
    rd_cnt(v); check("R4 R7 ext ratio 2", v, 8'h52);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule